// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This peripheral holds one 16-bit counter and a shared 16-bit reload/capture register. An 8-bit control byte and a small auxiliary byte choose one of four modes for the counter. In auto-reload mode the counter counts up or down between a programmed value and the top of its range. In capture mode it snapshots the running count when the trigger pin falls. In clock-out mode each overflow toggles a pin. In baud mode the overflow pulses become bit-rate ticks for a serial port. The counter advances on a prescaled clock-enable or on falling edges of an external count pin. Both pins pass through a two-stage synchronizer before edge detection.

Software reaches every register through a byte-wide read/write port. The read path is combinational. Two sticky flags, overflow and external event, are set by hardware, cleared only by a software write, and ORed onto the interrupt request.

Top module: `tmr16_multimode`

## Requirements
- R1: After reset, every register reads 00h, `irq` and `clkOutPin` are low, and the tick outputs follow `altOvf`.
- R2: Mode decode, with the first match winning:
  - run bit (control bit 2) clear: off.
  - either tick-select bit (control bits 5 and 4) set: baud.
  - capture bit (control bit 0) set: capture.
  - clock-out enable (aux bit 0) set: clock-out.
  - otherwise: auto-reload.
- R3: With the source bit (control bit 1) clear, the counter steps once per cycle in which `tickEn` is high. With it set, the counter steps once per falling edge of `cntPin` and ignores `tickEn`. When off, the counter holds its value.
- R4: The overflow flag (control bit 7) is set only on an overflow in capture or auto-reload mode. It is cleared only by a control write. A hardware set in the same cycle as a clearing write wins.
- R5: In capture mode with the edge enable (control bit 3) set, a trigger fall copies the counter into the reload/capture register and sets the external flag (bit 6). The counter keeps running. An overflow from FFFFh wraps to 0000h.
- R6: In upward auto-reload, a step at FFFFh loads the counter from the reload register and sets the overflow flag. With aux bit 1 clear and the edge enable set, a trigger fall also reloads the counter and sets the external flag.
- R7: With aux bit 1 set and the synchronized trigger low, auto-reload counts down. A step while the counter equals the reload value loads FFFFh and sets the overflow flag. With the trigger high, it counts up.
- R8: In clock-out mode each overflow toggles `clkOutPin` and reloads the counter. The overflow flag stays clear.
- R9: In baud mode an overflow reloads the counter and pulses `rxTick` and/or `txTick`, according to select bits 5 and 4, in the cycle of the overflow step. A tick whose select bit is clear copies `altOvf`. The overflow flag stays clear.
- R10: The external flag is set only when the edge enable is on and the mode is capture, auto-reload or baud. In baud mode the trigger does not alter the counter.
- R11: `irq` is high while either sticky flag is set.
- R12: Register addresses: 0 control, 1 aux (bits 1:0 only), 2/3 counter low/high, 4/5 reload/capture low/high. Other addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| tickEn | input | 1 | Prescaled count enable (timer source) |
| cntPin | input | 1 | External count pin, asynchronous |
| trigPin | input | 1 | External trigger / direction pin, asynchronous |
| altOvf | input | 1 | Alternate tick source for the serial port |
| irq | output | 1 | Interrupt request |
| rxTick | output | 1 | Receive bit-rate tick |
| txTick | output | 1 | Transmit bit-rate tick |
| clkOutPin | output | 1 | Clock-out pin level |

## Verification
On every cycle, assertions check three things. The overflow flag rises only from counting modes, and the external flag only when the edge enable is set. The counter moves only under a datapath strobe, with at most one counter action at a time. A capture holds the count of the previous cycle, and the clock-out pin changes only on a toggle strobe. The directed scenarios cover the rest: the actual count values, reload targets, direction switching on the trigger level, tick pulse rates in baud mode, mode priority, and the clash between a set and a clearing write.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_AUX    = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RC_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RC_HI  = 3'd5;

  // control byte fields
  localparam int B_OVF  = 7;
  localparam int B_EXT  = 6;
  localparam int B_RXS  = 5;
  localparam int B_TXS  = 4;
  localparam int B_EXEN = 3;
  localparam int B_RUN  = 2;
  localparam int B_CSEL = 1;
  localparam int B_CAP  = 0;

  // aux byte fields
  localparam int B_CLKOE = 0;
  localparam int B_DIREN = 1;
  localparam logic [BYTE_W-1:0] AUX_MASK = 8'h03;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_RELOAD,
    MODE_CAPT,
    MODE_CLKO,
    MODE_BAUD
  } mode_e;

  typedef struct packed {
    logic inc;
    logic dec;
    logic loadRc;
    logic loadMax;
    logic capture;
    logic toggleOut;
  } dpStrobe_t;
endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  input  logic              tickEn,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              altOvf,
  input  logic              cntAtMax,
  input  logic              cntAtRc,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic [BYTE_W-1:0] auxReg,
  output dpStrobe_t         strobe,
  output logic              irq,
  output logic              rxTick,
  output logic              txTick
);
  localparam int NPIN   = 2;
  localparam int P_CNT  = 0;
  localparam int P_TRIG = 1;

  logic [NPIN-1:0] pinIn;
  logic [NPIN-1:0] pinLvl;
  logic [NPIN-1:0] pinFall;
  assign pinIn = {trigPin, cntPin};

  // synchronizer plus one history stage for fall detection, per pin
  for (genvar g = 0; g < NPIN; g++) begin : gSync
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (!rstN) sh <= '1;
      else       sh <= {sh[SYNC_STAGES-1:0], pinIn[g]};
    end
    assign pinLvl[g]  = sh[SYNC_STAGES-1];
    assign pinFall[g] = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];
  end

  logic  ctrlWe, auxWe;
  logic  run, rxSel, txSel, extEn, srcSel, capSel, clkOe, dirEn;
  mode_e mode;
  logic  stepEvt, countUp, ovfEvt, extQual, extEvt, extReload, setOvf;

  assign ctrlWe = regWe && (regAddr == A_CTRL);
  assign auxWe  = regWe && (regAddr == A_AUX);
  assign run    = ctrlReg[B_RUN];
  assign rxSel  = ctrlReg[B_RXS];
  assign txSel  = ctrlReg[B_TXS];
  assign extEn  = ctrlReg[B_EXEN];
  assign srcSel = ctrlReg[B_CSEL];
  assign capSel = ctrlReg[B_CAP];
  assign clkOe  = auxReg[B_CLKOE];
  assign dirEn  = auxReg[B_DIREN];

  always_comb begin
    if (!run)                mode = MODE_OFF;
    else if (rxSel || txSel) mode = MODE_BAUD;
    else if (capSel)         mode = MODE_CAPT;
    else if (clkOe)          mode = MODE_CLKO;
    else                     mode = MODE_RELOAD;
  end

  assign stepEvt   = run && (srcSel ? pinFall[P_CNT] : tickEn);
  assign countUp   = !((mode == MODE_RELOAD) && dirEn && !pinLvl[P_TRIG]);
  assign ovfEvt    = stepEvt && (countUp ? cntAtMax : cntAtRc);
  assign extQual   = extEn && ((mode == MODE_CAPT) || (mode == MODE_RELOAD) ||
                               (mode == MODE_BAUD));
  assign extEvt    = extQual && pinFall[P_TRIG];
  assign extReload = extEvt && (mode == MODE_RELOAD) && !dirEn;
  assign setOvf    = ovfEvt && ((mode == MODE_CAPT) || (mode == MODE_RELOAD));

  always_comb begin
    strobe = '0;
    if (extReload) begin
      strobe.loadRc = 1'b1;
    end else if (stepEvt) begin
      if (!countUp) begin
        if (cntAtRc) strobe.loadMax = 1'b1;
        else         strobe.dec     = 1'b1;
      end else if (cntAtMax && (mode != MODE_CAPT)) begin
        strobe.loadRc = 1'b1;
      end else begin
        strobe.inc = 1'b1;
      end
    end
    strobe.capture   = extEvt && (mode == MODE_CAPT);
    strobe.toggleOut = ovfEvt && (mode == MODE_CLKO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      auxReg  <= '0;
    end else begin
      if (ctrlWe) ctrlReg <= regWdata;
      // hardware set takes priority over a clearing write in the same cycle
      if (setOvf) ctrlReg[B_OVF] <= 1'b1;
      if (extEvt) ctrlReg[B_EXT] <= 1'b1;
      if (auxWe)  auxReg <= regWdata & AUX_MASK;
    end
  end

  assign irq    = ctrlReg[B_OVF] | ctrlReg[B_EXT];
  assign rxTick = rxSel ? ovfEvt : altOvf;
  assign txTick = txSel ? ovfEvt : altOvf;

  // R4: overflow flag rises without a write only from a counting mode
  a_r4_ovf_from_counting_mode: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlReg[B_OVF]) && !$past(ctrlWe)) |->
      $past((mode == MODE_CAPT) || (mode == MODE_RELOAD)));

  // R10: external flag rises without a write only with the edge enable in a qualifying mode
  a_r10_ext_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlReg[B_EXT]) && !$past(ctrlWe)) |->
      $past(extEn && (mode != MODE_CLKO) && (mode != MODE_OFF)));

  // R2: at most one counter action is requested per cycle
  a_r2_single_counter_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.inc, strobe.dec, strobe.loadRc, strobe.loadMax}));
endmodule

// File: rtl/tmr16_dp.sv
module tmr16_dp
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  input  dpStrobe_t         strobe,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rc,
  output logic              cntAtMax,
  output logic              cntAtRc,
  output logic              clkOut
);
  logic cntWe, rcWe, anyCntOp;

  assign cntWe    = regWe && ((regAddr == A_CNT_LO) || (regAddr == A_CNT_HI));
  assign rcWe     = regWe && ((regAddr == A_RC_LO) || (regAddr == A_RC_HI));
  assign anyCntOp = strobe.inc | strobe.dec | strobe.loadRc | strobe.loadMax;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cntWe) begin
      if (regAddr == A_CNT_LO) cnt[BYTE_W-1:0]     <= regWdata;
      else                     cnt[CNT_W-1:BYTE_W] <= regWdata;
    end else if (strobe.loadRc) begin
      cnt <= rc;
    end else if (strobe.loadMax) begin
      cnt <= '1;
    end else if (strobe.inc) begin
      cnt <= cnt + 1'b1;
    end else if (strobe.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rc <= '0;
    end else if (rcWe) begin
      if (regAddr == A_RC_LO) rc[BYTE_W-1:0]     <= regWdata;
      else                    rc[CNT_W-1:BYTE_W] <= regWdata;
    end else if (strobe.capture) begin
      rc <= cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 clkOut <= 1'b0;
    else if (strobe.toggleOut) clkOut <= ~clkOut;
  end

  assign cntAtMax = &cnt;
  assign cntAtRc  = (cnt == rc);

  // R3: the counter holds unless a strobe or a write moves it
  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(anyCntOp) && !$past(cntWe)) |-> $stable(cnt));

  // R5: a capture stores the count seen in the capture cycle
  a_r5_capture_copies_count: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.capture) && !$past(rcWe)) |-> (rc == $past(cnt)));

  // R8: the clock-out pin moves only on a toggle strobe
  a_r8_toggle_only_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (clkOut != $past(clkOut)) |-> $past(strobe.toggleOut));
endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode
  import tmr16_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       tickEn,
  input  logic       cntPin,
  input  logic       trigPin,
  input  logic       altOvf,
  output logic       irq,
  output logic       rxTick,
  output logic       txTick,
  output logic       clkOutPin
);
  dpStrobe_t         strobe;
  logic [BYTE_W-1:0] ctrlReg, auxReg;
  logic [CNT_W-1:0]  cnt, rc;
  logic              cntAtMax, cntAtRc;

  tmr16_ctrl #(.SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .tickEn(tickEn), .cntPin(cntPin), .trigPin(trigPin), .altOvf(altOvf),
    .cntAtMax(cntAtMax), .cntAtRc(cntAtRc), .ctrlReg(ctrlReg), .auxReg(auxReg),
    .strobe(strobe), .irq(irq), .rxTick(rxTick), .txTick(txTick)
  );

  tmr16_dp uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .strobe(strobe), .cnt(cnt), .rc(rc), .cntAtMax(cntAtMax), .cntAtRc(cntAtRc),
    .clkOut(clkOutPin)
  );

  // R12: read decode
  always_comb begin
    case (regAddr)
      A_CTRL:   regRdata = ctrlReg;
      A_AUX:    regRdata = auxReg;
      A_CNT_LO: regRdata = cnt[BYTE_W-1:0];
      A_CNT_HI: regRdata = cnt[CNT_W-1:BYTE_W];
      A_RC_LO:  regRdata = rc[BYTE_W-1:0];
      A_RC_HI:  regRdata = rc[CNT_W-1:BYTE_W];
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: tb/sim_tmr16_multimode.sv
module sim_tmr16_multimode;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       tickEn = 1'b0, cntPin = 1'b1, trigPin = 1'b1, altOvf = 1'b0;
  logic       irq, rxTick, txTick, clkOutPin;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  tmr16_multimode u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .tickEn(tickEn), .cntPin(cntPin), .trigPin(trigPin),
    .altOvf(altOvf), .irq(irq), .rxTick(rxTick), .txTick(txTick), .clkOutPin(clkOutPin)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic rd16(input logic [2:0] aLo, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(aLo, lo);
    rd(aLo + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic wr16(input logic [2:0] aLo, input logic [15:0] v);
    wr(aLo, v[7:0]);
    wr(aLo + 3'd1, v[15:8]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic trigFall();
    @(negedge clk); trigPin = 1'b0; waitCyc(5);
  endtask

  task automatic trigRise();
    @(negedge clk); trigPin = 1'b1; waitCyc(5);
  endtask

  task automatic expectCtrl(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    rd(3'd0, d);
    check(tag, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic expectCnt(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    rd16(3'd2, v);
    check(tag, v, exp);
  endtask

  task automatic expectRc(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    rd16(3'd4, v);
    check(tag, v, exp);
  endtask

  task automatic tReset();
    logic [7:0] d;
    expectCtrl("R1 ctrl after reset", 8'h00);
    rd(3'd1, d); check("R1 aux after reset", {8'h00, d}, 16'h0000);
    expectCnt("R1 counter after reset", 16'h0000);
    expectRc("R1 reload after reset", 16'h0000);
    check("R1 irq low", {15'd0, irq}, 16'd0);
    check("R1 clkOut low", {15'd0, clkOutPin}, 16'd0);
    check("R1 rxTick follows altOvf", {15'd0, rxTick}, 16'd0);
    rd(3'd7, d); check("R12 unused address reads zero", {8'h00, d}, 16'h0000);
  endtask

  task automatic tTimer();
    wr16(3'd2, 16'h0000);
    wr(3'd0, 8'h04);
    ticks(10);
    expectCnt("R3 timer counts tickEn", 16'd10);
    wr(3'd0, 8'h00);
    ticks(5);
    expectCnt("R3 off holds count", 16'd10);
  endtask

  task automatic tCounter();
    wr(3'd0, 8'h06);
    @(negedge clk); tickEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cntPin = 1'b0; waitCyc(4);
      cntPin = 1'b1; waitCyc(4);
    end
    tickEn = 1'b0;
    expectCnt("R3 counter mode counts pin falls only", 16'd13);
    wr(3'd0, 8'h00);
  endtask

  task automatic tReloadUp();
    wr16(3'd4, 16'h1234);
    wr16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h04);
    ticks(2);
    expectCnt("R6 up overflow reloads", 16'h1234);
    expectCtrl("R4 overflow flag set in reload", 8'h84);
    check("R11 irq on overflow flag", {15'd0, irq}, 16'd1);
    ticks(1);
    expectCnt("R6 counting resumes after reload", 16'h1235);
    wr(3'd0, 8'h04);
    expectCtrl("R4 software clears overflow flag", 8'h04);
    check("R11 irq drops when flags clear", {15'd0, irq}, 16'd0);
    wr(3'd0, 8'h0C);
    trigFall();
    expectCnt("R6 trigger fall reloads", 16'h1234);
    expectCtrl("R6 trigger fall sets external flag", 8'h4C);
    check("R11 irq on external flag", {15'd0, irq}, 16'd1);
    trigRise();
    wr16(3'd2, 16'hFFFF);
    wr(3'd0, 8'h04);
    ticks(1);
    expectCtrl("R4 overflow sets flag again", 8'h84);
    wr16(3'd2, 16'hFFFF);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd0; regWdata = 8'h04; tickEn = 1'b1;
    @(negedge clk);
    regWe = 1'b0; tickEn = 1'b0;
    expectCtrl("R4 hardware set beats clearing write", 8'h84);
    wr(3'd0, 8'h00);
    expectCtrl("R4 clear while off", 8'h00);
  endtask

  task automatic tDown();
    wr(3'd1, 8'h02);
    @(negedge clk); trigPin = 1'b0; waitCyc(5);
    wr16(3'd4, 16'h0010);
    wr16(3'd2, 16'h0012);
    wr(3'd0, 8'h04);
    ticks(2);
    expectCnt("R7 down count reaches reload value", 16'h0010);
    expectCtrl("R7 no flag before wrap", 8'h04);
    ticks(1);
    expectCnt("R7 down wrap to FFFF", 16'hFFFF);
    expectCtrl("R7 down wrap sets overflow", 8'h84);
    ticks(1);
    expectCnt("R7 continues down", 16'hFFFE);
    trigRise();
    ticks(1);
    expectCnt("R7 trigger high counts up", 16'hFFFF);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic tCapture();
    wr16(3'd2, 16'h0100);
    wr(3'd0, 8'h0D);
    ticks(5);
    trigFall();
    expectRc("R5 capture copies counter", 16'h0105);
    expectCtrl("R5 capture sets external flag", 8'h4D);
    ticks(3);
    expectCnt("R5 counter keeps running", 16'h0108);
    expectRc("R5 capture register holds", 16'h0105);
    trigRise();
    wr(3'd0, 8'h0D);
    wr16(3'd2, 16'hFFFF);
    ticks(1);
    expectCnt("R5 capture overflow wraps to zero", 16'h0000);
    expectCtrl("R5 capture overflow sets flag", 8'h8D);
    wr(3'd0, 8'h05);
    expectCtrl("R10 capture with edge enable off", 8'h05);
    trigFall();
    expectCtrl("R10 no external flag when disabled", 8'h05);
    expectRc("R10 no capture when disabled", 16'h0105);
    trigRise();
    wr(3'd0, 8'h00);
  endtask

  task automatic tClockOut();
    wr(3'd1, 8'h01);
    wr16(3'd4, 16'hFFFD);
    wr16(3'd2, 16'hFFFD);
    wr(3'd0, 8'h0C);
    ticks(3);
    check("R8 overflow toggles pin high", {15'd0, clkOutPin}, 16'd1);
    expectCnt("R8 clock-out reloads", 16'hFFFD);
    expectCtrl("R8 no overflow flag", 8'h0C);
    trigFall();
    expectCtrl("R10 no external flag in clock-out", 8'h0C);
    trigRise();
    ticks(3);
    check("R8 second overflow toggles pin low", {15'd0, clkOutPin}, 16'd0);
    wr(3'd0, 8'h00);
    // R2: capture outranks clock-out enable
    wr16(3'd2, 16'hFFFF);
    wr(3'd0, 8'h05);
    ticks(1);
    expectCnt("R2 capture beats clock-out", 16'h0000);
    check("R2 no toggle under capture", {15'd0, clkOutPin}, 16'd0);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic tBaud();
    int nRx = 0, nTx = 0;
    wr16(3'd4, 16'hFFFE);
    wr16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h35);
    @(negedge clk); tickEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      nRx += int'(rxTick);
      nTx += int'(txTick);
      @(negedge clk);
    end
    tickEn = 1'b0;
    check("R9 rx ticks on overflow", nRx[15:0], 16'd3);
    check("R9 tx ticks on overflow", nTx[15:0], 16'd3);
    expectCnt("R9 baud reloads", 16'hFFFE);
    expectCtrl("R9 R2 baud beats capture, no flag", 8'h35);
    wr(3'd0, 8'h14);
    altOvf = 1'b1; #1;
    check("R9 rx follows altOvf", {15'd0, rxTick}, 16'd1);
    check("R9 tx idle without overflow", {15'd0, txTick}, 16'd0);
    altOvf = 1'b0;
    wr(3'd0, 8'h1C);
    trigFall();
    expectCtrl("R10 baud external flag", 8'h5C);
    expectCnt("R10 baud trigger leaves counter", 16'hFFFE);
    trigRise();
    wr(3'd0, 8'h00);
  endtask

  task automatic runAll();
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    tReset();
    tTimer();
    tCounter();
    tReloadUp();
    tDown();
    tCapture();
    tClockOut();
    tBaud();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule